// File: doc/BRIEF.md
# Store Queue with Writeback Pointer

This block holds the stores of one thread of an out-of-order core. It keeps them from dispatch until the data cache has accepted and finished each write. Entries sit in a circular buffer that has three pointers. The head points at the oldest live entry. The writeback pointer points at the oldest committed store not yet sent to the cache. The tail points at the next free slot.

Dispatch allocates an entry at the tail and tags it with a sequence number. Execution later fills in the address, access size and data. A commit sequence number marks every older store as allowed to write back. The writeback port then sends those stores to the cache in order, one per cycle, unless the cache reports blocked.

An entry is freed only after the cache reports its write complete. Committing or sending it does not free it. A squash sequence number trims younger, uncommitted entries off the tail.

Top module: `store_queue`

## Requirements
- R1: After reset, occupancy is 0, full is 0, wb_pending is 0, wb_valid is 0 and alloc_idx is 0.
- R2: A request with alloc_valid=1 and full=0, and no squash in the same cycle, writes the entry at alloc_idx. After that edge, occupancy is one higher and alloc_idx is one higher.
- R3: full is 1 exactly when occupancy is at least DEPTH-1. An allocation request while full is ignored: alloc_idx and occupancy do not change.
- R4: A commit with commit_seq=N marks every live entry whose sequence number is strictly less than N. wb_pending counts the marked entries that have not yet been sent to the cache.
- R5: wb_valid is 1 in a cycle only when the entry at the writeback pointer is live, marked, executed, not yet sent and not completed, and cache_blocked is 0. wb_idx, wb_addr, wb_size and wb_data then show that entry. Each such cycle advances the writeback pointer by one entry.
- R6: An entry whose stored size is 0 (allocated but not yet executed) is never sent. The writeback port waits at that entry until it is executed.
- R7: wb_done with wb_done_idx marks that entry completed. Occupancy drops only when the entry at the head is completed, and then by one entry per cycle in order. Committing or sending an entry does not change occupancy.
- R8: A squash with squash_seq=N removes every entry whose sequence number is greater than N, starting from the tail. It never removes a committed entry, and alloc_idx moves back to just after the last kept entry.
- R9: The head, writeback and tail indices wrap from DEPTH-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate an entry at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the allocated store |
| alloc_idx | output | IW | Index the next allocation will use |
| exec_valid | input | 1 | Write execution results into an entry |
| exec_idx | input | IW | Entry being executed |
| exec_addr | input | ADDR_W | Store address |
| exec_size | input | SIZE_W | Access size in bytes (0 means no data) |
| exec_data | input | DATA_W | Store data |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Stores older than this number are committed |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Stores younger than this number are removed |
| cache_blocked | input | 1 | Cache cannot accept a write this cycle |
| wb_valid | output | 1 | Write request to the cache this cycle |
| wb_idx | output | IW | Entry of the write request |
| wb_addr | output | ADDR_W | Address of the write request |
| wb_size | output | SIZE_W | Size of the write request |
| wb_data | output | DATA_W | Data of the write request |
| wb_done | input | 1 | A write has completed |
| wb_done_idx | input | IW | Entry whose write completed |
| occupancy | output | IW+1 | Number of live entries |
| full | output | 1 | Queue cannot take another store |
| wb_pending | output | IW+1 | Committed stores not yet sent |

## Verification
A writeback pointer that has drifted shows up as a request with the wrong wb_idx or data, or as the same index sent twice. This appears in the first cycle the cache is unblocked. A head that frees entries too early shows up as occupancy falling at commit or send time, or before the oldest write completes. The bench therefore holds completions out of order. A squash that counts its kept run wrongly shows up in the next cycle as the wrong alloc_idx or occupancy, or as a committed store that is never sent.

// File: rtl/store_queue.sv
module store_queue #(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4,
  parameter int DATA_W = 64,
  localparam int IW    = $clog2(DEPTH),
  localparam int CW    = IW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [SEQ_W-1:0]  alloc_seq,
  output logic [IW-1:0]     alloc_idx,
  input  logic              exec_valid,
  input  logic [IW-1:0]     exec_idx,
  input  logic [ADDR_W-1:0] exec_addr,
  input  logic [SIZE_W-1:0] exec_size,
  input  logic [DATA_W-1:0] exec_data,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  input  logic              cache_blocked,
  output logic              wb_valid,
  output logic [IW-1:0]     wb_idx,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [SIZE_W-1:0] wb_size,
  output logic [DATA_W-1:0] wb_data,
  input  logic              wb_done,
  input  logic [IW-1:0]     wb_done_idx,
  output logic [CW-1:0]     occupancy,
  output logic              full,
  output logic [CW-1:0]     wb_pending
);

  logic [IW-1:0]     head, wbp, tail;
  logic [CW-1:0]     count;
  logic [DEPTH-1:0]  live, can_wb, sent, cmpl;
  logic [SEQ_W-1:0]  seq_q  [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [SIZE_W-1:0] size_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];

  logic          alloc_fire, free_fire;
  logic [CW-1:0] kept, pend;

  assign occupancy  = count;
  assign full       = count >= CW'(DEPTH - 1);
  assign alloc_idx  = tail;
  assign alloc_fire = alloc_valid && !full && !squash_valid;
  assign free_fire  = live[head] && cmpl[head];

  assign wb_idx   = wbp;
  assign wb_addr  = addr_q[wbp];
  assign wb_size  = size_q[wbp];
  assign wb_data  = data_q[wbp];
  assign wb_valid = live[wbp] && can_wb[wbp] && !sent[wbp] && !cmpl[wbp] &&
                    (size_q[wbp] != '0) && !cache_blocked;
  assign wb_pending = pend;

  always_comb begin
    logic          run;
    logic [IW-1:0] idx;
    kept = '0;
    run  = 1'b1;
    pend = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + IW'(k);
      if (run && (CW'(k) < count) && (can_wb[idx] || seq_q[idx] <= squash_seq))
        kept = kept + 1'b1;
      else
        run = 1'b0;
      if (live[k] && can_wb[k] && !sent[k]) pend = pend + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head   <= '0;
      wbp    <= '0;
      tail   <= '0;
      count  <= '0;
      live   <= '0;
      can_wb <= '0;
      sent   <= '0;
      cmpl   <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        seq_q[i]  <= '0;
        addr_q[i] <= '0;
        size_q[i] <= '0;
        data_q[i] <= '0;
      end
    end else begin
      if (exec_valid && live[exec_idx]) begin
        addr_q[exec_idx] <= exec_addr;
        size_q[exec_idx] <= exec_size;
        data_q[exec_idx] <= exec_data;
      end
      if (commit_valid) begin
        for (int i = 0; i < DEPTH; i++)
          if (live[i] && seq_q[i] < commit_seq) can_wb[i] <= 1'b1;
      end
      if (wb_valid) begin
        sent[wbp] <= 1'b1;
        wbp       <= wbp + 1'b1;
      end
      if (wb_done && live[wb_done_idx]) cmpl[wb_done_idx] <= 1'b1;

      if (squash_valid) begin
        tail  <= head + kept[IW-1:0];
        count <= kept - CW'(free_fire);
        for (int i = 0; i < DEPTH; i++)
          if (CW'(IW'(i) - head) >= kept) live[i] <= 1'b0;
      end else begin
        tail  <= tail + IW'(alloc_fire);
        count <= count + CW'(alloc_fire) - CW'(free_fire);
      end

      if (alloc_fire) begin
        live[tail]   <= 1'b1;
        can_wb[tail] <= 1'b0;
        sent[tail]   <= 1'b0;
        cmpl[tail]   <= 1'b0;
        seq_q[tail]  <= alloc_seq;
        size_q[tail] <= '0;
      end
      if (free_fire) begin
        live[head]   <= 1'b0;
        can_wb[head] <= 1'b0;
        sent[head]   <= 1'b0;
        cmpl[head]   <= 1'b0;
        head         <= head + 1'b1;
      end
    end
  end

endmodule

// File: rtl/store_queue_checker.sv
module store_queue_checker #(
  parameter int DEPTH  = 8,
  parameter int SIZE_W = 4,
  localparam int IW    = $clog2(DEPTH),
  localparam int CW    = IW + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alloc_valid,
  input logic              squash_valid,
  input logic              cache_blocked,
  input logic [IW-1:0]     alloc_idx,
  input logic              wb_valid,
  input logic [IW-1:0]     wb_idx,
  input logic [SIZE_W-1:0] wb_size,
  input logic [CW-1:0]     occupancy,
  input logic              full,
  input logic [CW-1:0]     wb_pending
);

  a_r5_blocked_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    cache_blocked |-> !wb_valid);

  a_r5_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !(wb_valid && wb_idx == $past(wb_idx)));

  a_r6_size_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_size != '0);

  a_r3_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= CW'(DEPTH - 1));

  a_r3_full_alloc_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    full && alloc_valid && !squash_valid |=> alloc_idx == $past(alloc_idx));

  a_r4_pending_le_occ: assert property (@(posedge clk) disable iff (!rst_n)
    wb_pending <= occupancy);

endmodule

bind store_queue store_queue_checker #(.DEPTH(DEPTH), .SIZE_W(SIZE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .squash_valid(squash_valid),
  .cache_blocked(cache_blocked), .alloc_idx(alloc_idx), .wb_valid(wb_valid),
  .wb_idx(wb_idx), .wb_size(wb_size), .occupancy(occupancy), .full(full),
  .wb_pending(wb_pending)
);

// File: tb/test_store_queue.sv
module test_store_queue;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8, SEQ_W = 16, ADDR_W = 32, SIZE_W = 4, DATA_W = 64;
  localparam int IW = $clog2(DEPTH), CW = IW + 1;

  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0, exec_valid = 0, commit_valid = 0, squash_valid = 0;
  logic cache_blocked = 0, wb_done = 0;
  logic [SEQ_W-1:0] alloc_seq = '0, commit_seq = '0, squash_seq = '0;
  logic [IW-1:0] exec_idx = '0, wb_done_idx = '0;
  logic [ADDR_W-1:0] exec_addr = '0;
  logic [SIZE_W-1:0] exec_size = '0;
  logic [DATA_W-1:0] exec_data = '0;
  logic [IW-1:0] alloc_idx, wb_idx;
  logic wb_valid, full;
  logic [ADDR_W-1:0] wb_addr;
  logic [SIZE_W-1:0] wb_size;
  logic [DATA_W-1:0] wb_data;
  logic [CW-1:0] occupancy, wb_pending;

  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  store_queue #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W),
                .DATA_W(DATA_W)) i_store_queue (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_seq(alloc_seq),
    .alloc_idx(alloc_idx), .exec_valid(exec_valid), .exec_idx(exec_idx),
    .exec_addr(exec_addr), .exec_size(exec_size), .exec_data(exec_data),
    .commit_valid(commit_valid), .commit_seq(commit_seq),
    .squash_valid(squash_valid), .squash_seq(squash_seq),
    .cache_blocked(cache_blocked), .wb_valid(wb_valid), .wb_idx(wb_idx),
    .wb_addr(wb_addr), .wb_size(wb_size), .wb_data(wb_data), .wb_done(wb_done),
    .wb_done_idx(wb_done_idx), .occupancy(occupancy), .full(full),
    .wb_pending(wb_pending));

  task automatic check(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    alloc_valid = 0; exec_valid = 0; commit_valid = 0; squash_valid = 0; wb_done = 0;
  endtask

  task automatic do_alloc(int seq);
    alloc_valid = 1; alloc_seq = SEQ_W'(seq); tick();
  endtask

  task automatic do_exec(int idx, int size, longint data);
    exec_valid = 1; exec_idx = IW'(idx); exec_size = SIZE_W'(size);
    exec_addr = ADDR_W'(32'h100 + idx * 8); exec_data = DATA_W'(data); tick();
  endtask

  task automatic do_done(int idx);
    wb_done = 1; wb_done_idx = IW'(idx); tick();
  endtask

  task automatic t_reset();
    check("R1 occupancy", occupancy, 0);
    check("R1 full", full, 0);
    check("R1 wb_pending", wb_pending, 0);
    check("R1 wb_valid", wb_valid, 0);
    check("R1 alloc_idx", alloc_idx, 0);
  endtask

  task automatic t_alloc_and_writeback();
    cache_blocked = 1;
    for (int i = 0; i < 3; i++) begin
      check("R2 alloc_idx before", alloc_idx, i);
      do_alloc(10 + i);
    end
    check("R2 occupancy", occupancy, 3);
    do_exec(0, 4, 64'hAAAA);
    do_exec(1, 8, 64'hBBBB);
    commit_valid = 1; commit_seq = 13; tick();
    check("R4 pending after commit", wb_pending, 3);
    check("R5 blocked no write", wb_valid, 0);
    cache_blocked = 0; #1;
    check("R5 valid", wb_valid, 1);
    check("R5 idx", wb_idx, 0);
    check("R5 data", wb_data, 64'hAAAA);
    check("R5 size", wb_size, 4);
    tick();
    check("R5 next idx", wb_idx, 1);
    check("R5 next data", wb_data, 64'hBBBB);
    check("R5 addr", wb_addr, 32'h108);
    tick();
    check("R6 unexecuted not sent", wb_valid, 0);
    check("R4 pending one left", wb_pending, 1);
    check("R7 not freed by send", occupancy, 3);
    cache_blocked = 1;
    do_exec(2, 2, 64'hCC);
    cache_blocked = 0; #1;
    check("R6 sent after exec", wb_valid, 1);
    check("R6 idx", wb_idx, 2);
    tick();
    check("R4 pending zero", wb_pending, 0);
  endtask

  task automatic t_completion();
    do_done(1);
    tick();
    check("R7 out of order done keeps head", occupancy, 3);
    do_done(0);
    check("R7 completed not yet freed", occupancy, 3);
    tick();
    check("R7 head frees one", occupancy, 2);
    tick();
    check("R7 head frees next", occupancy, 1);
    do_done(2);
    tick();
    check("R7 drained", occupancy, 0);
  endtask

  task automatic t_squash();
    for (int i = 0; i < 4; i++) do_alloc(20 + i);
    check("R2 alloc_idx after four", alloc_idx, 7);
    commit_valid = 1; commit_seq = 21; tick();
    check("R4 strict older only", wb_pending, 1);
    squash_valid = 1; squash_seq = 21; tick();
    check("R8 occupancy after squash", occupancy, 2);
    check("R8 alloc_idx after squash", alloc_idx, 5);
    squash_valid = 1; squash_seq = 15; tick();
    check("R8 committed kept", occupancy, 1);
    check("R8 alloc_idx back", alloc_idx, 4);
    check("R8 pending kept", wb_pending, 1);
  endtask

  task automatic t_full_wrap();
    for (int i = 0; i < 6; i++) do_alloc(30 + i);
    check("R9 alloc_idx wrapped", alloc_idx, 2);
    check("R3 occupancy at limit", occupancy, DEPTH - 1);
    check("R3 full", full, 1);
    do_alloc(40);
    check("R3 alloc ignored idx", alloc_idx, 2);
    check("R3 alloc ignored occ", occupancy, DEPTH - 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_alloc_and_writeback();
        t_completion();
        t_squash();
        t_full_wrap();
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule